// File: doc/BRIEF.md
# Single-Pin Serial Page-Write Decoder

This block is the device-side control logic of a small nonvolatile memory. The memory is attached to an ordinary parallel bus, but all addresses and data travel serially on one I/O pin. The host uses three active-low strobes: chip select, output enable and write enable. The block samples them with its own clock and classifies each bus cycle as a write cycle or a read cycle. It then decodes the order of those cycles into four phases: arming, address, data and commit.

The host first sends an arming pattern of cycles. This sets a write-enable latch. The host then shifts in a 16-bit address and some whole data bytes, MSB first, into a 32-byte page buffer. A three-cycle commit closes the sequence. After a valid commit, the block is busy for a modelled period. At the end of that period it copies the loaded bytes into a small register-array memory. During the busy period, any read cycle returns the write status on the I/O pin. Only the order of cycles matters: idle time between cycles has no effect.

Top module: `pin_serial_page_writer`

## Requirements
- R1: A write cycle is chip select low, write enable low and output enable high. A read cycle is chip select low, output enable low and write enable high. Each cycle is counted once, when it begins. Strobe activity while chip select is high is ignored, and so is a low chip select with both enables low.
- R2: The arming pattern is read, write of 0, read. Without the arming pattern, address, data and commit cycles change nothing in the memory.
- R3: After arming, the next 16 write cycles form the address, MSB first. Address bits [4:0] give the first byte offset in the page. Bits [6:5] select one of the 4 pages, and the higher bits are ignored.
- R4: The data write cycles that follow form bytes, MSB first. The bytes are stored at successive offsets from the start offset, and the offset wraps from 31 back to 0.
- R5: A read cycle during the address phase aborts the sequence and clears the latch. Later cycles then change nothing until the host arms the block again.
- R6: The commit is a read, then a write of 1, then a read. Any other cycle in either of the last two positions aborts the sequence without writing.
- R7: If the first read after the data phase comes when the bit count is not a multiple of 8, or when no whole byte has been loaded, the sequence aborts and nothing is written.
- R8: The busy period starts at the clock edge that samples the final commit read and lasts BUSY_CYCLES clocks. During a read cycle the pin is driven (io_oe=1): it reads 0 while busy and 1 otherwise. An arming pattern issued while busy changes neither of these.
- R9: At the end of the busy period, only the loaded page bytes are written to memory and the latch is cleared. A new sequence that is not armed again is ignored.
- R10: Idle time of any length between cycles does not change the result.
- R11: Loading more than 32 bytes overwrites earlier bytes at the wrapped offsets, so the last byte loaded for each offset is the one stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Bus chip select, active low |
| oe_n | input | 1 | Bus output enable, active low |
| we_n | input | 1 | Bus write enable, active low |
| io_in | input | 1 | Serial value on the I/O pin |
| io_out | output | 1 | Write status driven onto the pin (1 = idle) |
| io_oe | output | 1 | Pin drive enable, high during a read cycle |
| peek_addr | input | 7 | Memory byte index {page, offset} for inspection |
| peek_data | output | 8 | Memory byte at peek_addr |

## Verification
The main write path is swept across all 32 start offsets, with 1 to 3 bytes, rotating pages and changing upper address bits. This separates correct offset arithmetic, wrap and page selection from errors that only show at a single offset. Further runs use a page that crosses the top offset, a 34-byte overflow, and a sequence padded with idle gaps and ignored strobe cycles; these tell wrap, last-writer-wins and cycle-edge counting apart. Negative patterns cover a missing arming pattern, a read in the middle of the address, a partial byte, zero bytes, a broken commit, and an attempt to reuse the latch after a completed write. Each of these must leave the memory bit-for-bit equal to the bench model. The status pin is checked on the exact last busy cycle and the first idle cycle.

// File: rtl/pin_serial_page_writer.sv
module pin_serial_page_writer #(
  parameter int ADDR_BITS   = 16,
  parameter int PAGE_BYTES  = 32,
  parameter int PAGES       = 4,
  parameter int BUSY_CYCLES = 20,
  parameter int SEQ_LEN     = 3,
  parameter logic [SEQ_LEN-1:0] SEQ_IS_READ = 3'b101,
  parameter logic [SEQ_LEN-1:0] SEQ_WVAL    = 3'b000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic oe_n,
  input  logic we_n,
  input  logic io_in,
  output logic io_out,
  output logic io_oe,
  input  logic [$clog2(PAGES)+$clog2(PAGE_BYTES)-1:0] peek_addr,
  output logic [7:0] peek_data
);
  localparam int OFS_W  = $clog2(PAGE_BYTES);
  localparam int PG_W   = $clog2(PAGES);
  localparam int MEM_N  = PAGES * PAGE_BYTES;
  localparam int ACNT_W = $clog2(ADDR_BITS);
  localparam int CNT_W  = $clog2(BUSY_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_DATA, S_END, S_ONE, S_BUSY} st_t;

  st_t                 state;
  logic                wel, was_wr, was_rd;
  logic [SEQ_LEN-1:0]  hist_rd, hist_val;
  logic [ACNT_W-1:0]   acnt;
  logic [ADDR_BITS-1:0] addr_sh;
  logic [2:0]          bcnt;
  logic [6:0]          sh;
  logic [OFS_W-1:0]    ptr;
  logic [PAGE_BYTES-1:0] mask;
  logic [7:0]          pbuf [PAGE_BYTES];
  logic [7:0]          mem  [MEM_N];
  logic [CNT_W-1:0]    busy_cnt;

  wire is_wr  = ~cs_n & ~we_n & oe_n;
  wire is_rd  = ~cs_n & ~oe_n & we_n;
  wire wr_evt = is_wr & ~was_wr;
  wire rd_evt = is_rd & ~was_rd;
  wire evt    = wr_evt | rd_evt;

  wire [SEQ_LEN-1:0] nxt_rd  = {hist_rd[SEQ_LEN-2:0], rd_evt};
  wire [SEQ_LEN-1:0] nxt_val = {hist_val[SEQ_LEN-2:0], io_in};
  wire seq_hit = evt && (nxt_rd == SEQ_IS_READ) &&
                 (((nxt_val ^ SEQ_WVAL) & ~SEQ_IS_READ) == '0);

  wire [PG_W-1:0] page = addr_sh[OFS_W +: PG_W];

  assign io_oe     = is_rd;
  assign io_out    = (state != S_BUSY);
  assign peek_data = mem[peek_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      wel      <= 1'b0;
      was_wr   <= 1'b0;
      was_rd   <= 1'b0;
      hist_rd  <= '0;
      hist_val <= ~SEQ_WVAL;
      acnt     <= '0;
      addr_sh  <= '0;
      bcnt     <= '0;
      sh       <= '0;
      ptr      <= '0;
      mask     <= '0;
      busy_cnt <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= '0;
      for (int i = 0; i < MEM_N; i++) mem[i] <= '0;
    end else begin
      was_wr <= is_wr;
      was_rd <= is_rd;
      if (evt) begin
        hist_rd  <= nxt_rd;
        hist_val <= nxt_val;
      end
      if (state == S_BUSY) begin
        busy_cnt <= busy_cnt - 1'b1;
        if (busy_cnt == CNT_W'(1)) begin
          for (int i = 0; i < PAGE_BYTES; i++)
            if (mask[i]) mem[{page, OFS_W'(i)}] <= pbuf[i];
          state <= S_IDLE;
          wel   <= 1'b0;
        end
      end else if (seq_hit) begin
        wel   <= 1'b1;
        state <= S_ADDR;
        acnt  <= '0;
        bcnt  <= '0;
        mask  <= '0;
      end else if (evt) begin
        case (state)
          S_ADDR: begin
            if (rd_evt) begin
              state <= S_IDLE;
              wel   <= 1'b0;
            end else begin
              addr_sh <= {addr_sh[ADDR_BITS-2:0], io_in};
              acnt    <= acnt + 1'b1;
              if (acnt == ACNT_W'(ADDR_BITS - 1)) begin
                state <= S_DATA;
                ptr   <= {addr_sh[OFS_W-2:0], io_in};
              end
            end
          end
          S_DATA: begin
            if (rd_evt) begin
              if (bcnt == '0 && |mask) state <= S_END;
              else begin
                state <= S_IDLE;
                wel   <= 1'b0;
              end
            end else begin
              sh   <= {sh[5:0], io_in};
              bcnt <= bcnt + 1'b1;
              if (bcnt == 3'd7) begin
                pbuf[ptr] <= {sh, io_in};
                mask[ptr] <= 1'b1;
                ptr       <= ptr + 1'b1;
              end
            end
          end
          S_END: begin
            if (wr_evt && io_in) state <= S_ONE;
            else begin
              state <= S_IDLE;
              wel   <= 1'b0;
            end
          end
          S_ONE: begin
            if (rd_evt) begin
              state    <= S_BUSY;
              busy_cnt <= CNT_W'(BUSY_CYCLES);
            end else begin
              state <= S_IDLE;
              wel   <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_ce_high_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && state != S_BUSY) |=> ($stable(state) && $stable(ptr) && $stable(acnt)));

  assert_unarmed_stays_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && !seq_hit) |=> (state == S_IDLE));

  assert_addr_read_aborts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ADDR && rd_evt && !seq_hit) |=> (state == S_IDLE && !wel));

  assert_busy_only_via_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_ONE && state != S_BUSY) |=> (state != S_BUSY));

  assert_partial_byte_aborts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DATA && rd_evt && !seq_hit && bcnt != 3'd0) |=> (state == S_IDLE));

  assert_busy_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BUSY && busy_cnt != CNT_W'(1)) |=> (state == S_BUSY));

  assert_latch_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BUSY && busy_cnt == CNT_W'(1)) |=> (state == S_IDLE && !wel));
endmodule

// File: tb/tb_pin_serial_page_writer.sv
module tb_pin_serial_page_writer;
  localparam int B = 20;
  localparam int MEM_N = 128;

  logic clk = 0, rst_n = 0;
  logic cs_n = 1, oe_n = 1, we_n = 1, io_in = 0;
  logic io_out, io_oe;
  logic [6:0] peek_addr = '0;
  logic [7:0] peek_data;

  int checks = 0, errors = 0;
  bit gaps = 0;
  logic [7:0] dq [40];
  logic [7:0] exp_mem [MEM_N];

  pin_serial_page_writer #(.BUSY_CYCLES(B)) dut (
    .clk, .rst_n, .cs_n, .oe_n, .we_n, .io_in,
    .io_out, .io_oe, .peek_addr, .peek_data);

  always #5 clk = ~clk;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic junk();
    @(negedge clk); cs_n = 1; we_n = 1'($urandom); oe_n = 1'($urandom);
    @(negedge clk); cs_n = 0; we_n = 0; oe_n = 0;
    @(negedge clk); cs_n = 1; we_n = 1; oe_n = 1;
    repeat ($urandom % 3) @(negedge clk);
  endtask

  task automatic wr(bit b);
    if (gaps) junk();
    @(negedge clk); cs_n = 0; we_n = 0; oe_n = 1; io_in = b;
    @(negedge clk); cs_n = 1; we_n = 1; oe_n = 1;
  endtask

  task automatic rd(output bit v);
    if (gaps) junk();
    @(negedge clk); cs_n = 0; oe_n = 0; we_n = 1;
    #1 v = io_out;
    @(negedge clk); cs_n = 1; oe_n = 1;
  endtask

  task automatic arm();
    bit v;
    rd(v); wr(0); rd(v);
  endtask

  task automatic send_addr(logic [15:0] a, int from, int to);
    for (int i = from; i >= to; i--) wr(a[i]);
  endtask

  task automatic send_bytes(int n);
    for (int i = 0; i < n; i++)
      for (int k = 7; k >= 0; k--) wr(dq[i][k]);
  endtask

  task automatic commit();
    bit v;
    rd(v); wr(1); rd(v);
  endtask

  task automatic model(logic [15:0] a, int n);
    for (int i = 0; i < n; i++)
      exp_mem[int'(a[6:5]) * 32 + (int'(a[4:0]) + i) % 32] = dq[i];
  endtask

  task automatic check_mem(string req);
    int bad = -1;
    logic [7:0] got = '0;
    for (int i = 0; i < MEM_N; i++) begin
      @(negedge clk); peek_addr = 7'(i);
      #1 if (bad < 0 && peek_data !== exp_mem[i]) begin bad = i; got = peek_data; end
    end
    if (bad < 0) check(1, req, 0, 0);
    else begin
      checks++; errors++;
      $display("FAIL %s mem[%0d] actual=%0d expected=%0d", req, bad, got, exp_mem[bad]);
    end
  endtask

  task automatic fill(int seed, int n);
    for (int i = 0; i < n; i++) dq[i] = 8'(seed * 7 + i * 13 + 5);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit v;
    for (int i = 0; i < MEM_N; i++) exp_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1 check(io_oe == 0, "R8 reset no drive", io_oe, 0);
    check_mem("R1 reset memory");
    rd(v);
    check(v == 1, "R8 idle status", v, 1);

    // R2: no arming
    fill(1, 3);
    send_addr(16'h0020, 15, 0); send_bytes(3); commit();
    repeat (B + 3) @(negedge clk);
    check_mem("R2 unarmed ignored");

    // R3 R8: upper bits ignored, status boundary
    fill(2, 5);
    arm(); send_addr(16'hA023, 15, 0); send_bytes(5); commit();
    repeat (B - 2) @(negedge clk);
    @(negedge clk); cs_n = 0; oe_n = 0; we_n = 1;
    #1 check(io_out == 0 && io_oe == 1, "R8 last busy cycle", io_out, 0);
    @(negedge clk);
    #1 check(io_out == 1 && io_oe == 1, "R8 first idle cycle", io_out, 1);
    cs_n = 1; oe_n = 1;
    model(16'hA023, 5);
    check_mem("R3 page and offset");

    // R4: wrap
    fill(3, 4);
    arm(); send_addr(16'h005E, 15, 0); send_bytes(4); commit();
    repeat (B + 3) @(negedge clk);
    model(16'h005E, 4);
    check_mem("R4 wrap");

    // R11: overflow
    fill(4, 34);
    arm(); send_addr(16'h0060, 15, 0); send_bytes(34); commit();
    repeat (B + 3) @(negedge clk);
    model(16'h0060, 34);
    check_mem("R11 overflow");

    // R7: partial byte
    fill(5, 2);
    arm(); send_addr(16'h0000, 15, 0); send_bytes(2);
    wr(1); wr(0); wr(1); commit();
    rd(v);
    check(v == 1, "R7 partial no busy", v, 1);
    repeat (B + 3) @(negedge clk);
    check_mem("R7 partial byte");
    arm(); send_addr(16'h0004, 15, 0); commit();
    rd(v);
    check(v == 1, "R7 zero bytes no busy", v, 1);
    check_mem("R7 zero bytes");

    // R5: read inside address
    fill(6, 2);
    arm(); send_addr(16'h0041, 15, 11); rd(v);
    send_addr(16'h0041, 10, 0); send_bytes(2); commit();
    rd(v);
    check(v == 1, "R5 no busy", v, 1);
    check_mem("R5 address read abort");

    // R6: broken commits
    fill(7, 2);
    arm(); send_addr(16'h0021, 15, 0); send_bytes(2);
    rd(v); rd(v); wr(1); rd(v);
    rd(v);
    check(v == 1, "R6 read-read no busy", v, 1);
    check_mem("R6 read-read");
    arm(); send_addr(16'h0021, 15, 0); send_bytes(2);
    rd(v); wr(1); wr(1); rd(v);
    rd(v);
    check(v == 1, "R6 write-write no busy", v, 1);
    check_mem("R6 write-write");

    // R8 R9: arming while busy, latch cleared afterwards
    fill(8, 3);
    arm(); send_addr(16'h0048, 15, 0); send_bytes(3); commit();
    model(16'h0048, 3);
    arm(); rd(v);
    check(v == 0, "R8 arm during busy", v, 0);
    repeat (B + 3) @(negedge clk);
    rd(v);
    check(v == 1, "R8 done after arm in busy", v, 1);
    fill(9, 3);
    send_addr(16'h0048, 15, 0); send_bytes(3); commit();
    repeat (B + 3) @(negedge clk);
    check_mem("R9 latch cleared");

    // R10 R1: gaps and ignored strobes
    gaps = 1;
    fill(10, 6);
    arm(); send_addr(16'h000A, 15, 0); send_bytes(6); commit();
    gaps = 0;
    repeat (B + 3) @(negedge clk);
    model(16'h000A, 6);
    check_mem("R10 gaps R1 strobes");

    // R3 R4 sweep over offsets
    for (int off = 0; off < 32; off++) begin
      logic [15:0] a;
      int n;
      a = {9'(off * 37), 2'(off % 4), 5'(off)};
      n = 1 + off % 3;
      fill(off + 11, n);
      arm(); send_addr(a, 15, 0); send_bytes(n); commit();
      repeat (B + 3) @(negedge clk);
      model(a, n);
      check_mem("R3 R4 sweep");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule